// File: doc/BRIEF.md
# Microcontroller Interrupt Arbitration Unit

This unit sits beside the sequencer of a small 8-bit processor. At every instruction boundary it decides whether the core enters an interrupt sequence or fetches the next instruction. If it enters one, the unit also decides which source is serviced. Three sources are possible: an external request pin, a timer request, and a software-interrupt opcode.

The external pin is active-low and asynchronous to the core clock. A two-stage synchronizer feeds an edge detector. A falling edge on the pin records a pending external request. A one-cycle timer pulse records a pending timer request. Both records survive while the interrupt mask is set. They are serviced at the first instruction end after the mask clears. When both are eligible, external wins. The software interrupt ignores the mask but ranks below any eligible hardware request.

The unit owns the interrupt mask bit and sets it on every entry. The core can reload the mask in two ways: from the stacked copy when a return-from-interrupt completes, or by an ordinary instruction write. Register stacking and the vector fetch stay in the core. The unit only hands over a source code, a one-hot vector select and the acknowledges that clear the pending records.

Top module: `intArbiter`

## Requirements
- R1: A cycle with `rst` high sets the mask to 1 and clears both pending records. After it, an instruction end with no software request gives `fetchNext`=1 and `takeInt`=0.
- R2: A falling edge on `extReqN` sets the external pending record three clock edges later. The record clears only on `ackExt`. Holding the pin low after service does not set it again; only a new falling edge does.
- R3: A `tmrPulse` cycle sets the timer pending record. If a pulse arrives in the same cycle as `ackTmr`, the record stays set.
- R4: While the mask is 1, no hardware request is taken and its pending record is kept. The request is taken at the first instruction end after the mask becomes 0.
- R5: `takeInt`, `ackExt` and `ackTmr` can be high only in a cycle where `instrEnd` is high.
- R6: When both records are pending with the mask at 0, the external request is taken and the timer record stays set for a later boundary.
- R7: Every entry drives `setMask`=1, and `maskOut` reads 1 from the next cycle.
- R8: `swiDecode` at an instruction end is taken even when the mask is 1. It is not taken when an eligible hardware request is pending.
- R9: `rtiStrobe` loads `maskOut` from `stackedMask`, and `maskLoad` loads it from `maskLoadVal`. Entry outranks both loads, and the return-from-interrupt load outranks the instruction write.
- R10: At an instruction end with nothing taken, `fetchNext`=1, `srcCode`=00 and `vecSel`=000. Outside an instruction end, `fetchNext`=0.
- R11: `srcCode` is 11 for external, 10 for timer and 01 for software. The matching `vecSel` is 100, 010 and 001 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| extReqN | input | 1 | Asynchronous external request, active low |
| tmrPulse | input | 1 | One-cycle timer request |
| instrEnd | input | 1 | Current instruction completes this cycle |
| swiDecode | input | 1 | Instruction at this boundary is a software interrupt |
| rtiStrobe | input | 1 | Return-from-interrupt restores the mask this cycle |
| stackedMask | input | 1 | Mask value popped from the stack |
| maskLoad | input | 1 | Instruction writes the mask this cycle |
| maskLoadVal | input | 1 | Value written by that instruction |
| takeInt | output | 1 | Enter an interrupt sequence |
| srcCode | output | 2 | Serviced source code |
| vecSel | output | 3 | One-hot vector select (ext, timer, software) |
| setMask | output | 1 | Mask-set command on entry |
| ackExt | output | 1 | Clears the external pending record |
| ackTmr | output | 1 | Clears the timer pending record |
| fetchNext | output | 1 | Fetch next instruction normally |
| maskOut | output | 1 | Current interrupt mask |

## Verification
Directed sequences come first. Each raises external and timer requests while the mask is set and then releases the mask, once by an instruction write and once by a return-from-interrupt restore. This separates a latching design from one that drops masked requests, and it shows whether external outranks timer. A timer pulse that lands in the same cycle as its own acknowledge shows whether set wins over clear. A software request is given with the mask set, and again alongside an eligible hardware request, to pin down its rank. A held-low pin followed by a fresh edge shows edge detection rather than level sensing. A long random run then mixes every input against the behavioural model on every clock.

// File: rtl/intArbPkg.sv
package intArbPkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_SWI  = 2'b01,
    SRC_TMR  = 2'b10,
    SRC_EXT  = 2'b11
  } srcCode_e;

  localparam int VEC_W = 3;

  // control -> datapath strobes
  typedef struct packed {
    logic enter;
    logic ackExt;
    logic ackTmr;
  } ctlStrobe_t;

  // datapath -> control state
  typedef struct packed {
    logic extPend;
    logic tmrPend;
    logic mask;
  } pendState_t;

endpackage

// File: rtl/intArbPending.sv
module intArbPending
  import intArbPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       extReqN,
  input  logic       tmrPulse,
  input  logic       rtiStrobe,
  input  logic       stackedMask,
  input  logic       maskLoad,
  input  logic       maskLoadVal,
  input  ctlStrobe_t strobe,
  output pendState_t state
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] syncQ;
  logic         lastQ;
  logic         extFell;
  logic         extPendQ;
  logic         tmrPendQ;
  logic         maskQ;

  // synchronizer chain plus one delay for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ <= '1;
      lastQ <= 1'b1;
    end else begin
      syncQ <= {syncQ[TOP-1:0], extReqN};
      lastQ <= syncQ[TOP];
    end
  end

  assign extFell = lastQ & ~syncQ[TOP];

  // pending records: a new set beats a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) begin
      extPendQ <= 1'b0;
      tmrPendQ <= 1'b0;
    end else begin
      extPendQ <= extFell  | (extPendQ & ~strobe.ackExt);
      tmrPendQ <= tmrPulse | (tmrPendQ & ~strobe.ackTmr);
    end
  end

  // mask: reset/entry set, then return restore, then instruction write
  always_ff @(posedge clk) begin
    if (rst)               maskQ <= 1'b1;
    else if (strobe.enter) maskQ <= 1'b1;
    else if (rtiStrobe)    maskQ <= stackedMask;
    else if (maskLoad)     maskQ <= maskLoadVal;
  end

  assign state.extPend = extPendQ;
  assign state.tmrPend = tmrPendQ;
  assign state.mask    = maskQ;

  // R7: entry leaves the mask set
  a_r7_entry_sets_mask: assert property (@(posedge clk) disable iff (rst)
    strobe.enter |=> maskQ);

  // R4: hardware acknowledge only while unmasked
  a_r4_ack_needs_open_mask: assert property (@(posedge clk) disable iff (rst)
    (strobe.ackExt || strobe.ackTmr) |-> !maskQ);

  // R6: one hardware source per boundary
  a_r6_single_ack: assert property (@(posedge clk) disable iff (rst)
    !(strobe.ackExt && strobe.ackTmr));

  // R3: a timer pulse always leaves the record set
  a_r3_pulse_pends: assert property (@(posedge clk) disable iff (rst)
    tmrPulse |=> tmrPendQ);

  // R2: external acknowledge only for a pending record
  a_r2_ack_when_pending: assert property (@(posedge clk) disable iff (rst)
    strobe.ackExt |-> extPendQ);

endmodule

// File: rtl/intArbControl.sv
module intArbControl
  import intArbPkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             instrEnd,
  input  logic             swiDecode,
  input  pendState_t       state,
  output ctlStrobe_t       strobe,
  output logic             takeInt,
  output logic [1:0]       srcCode,
  output logic [VEC_W-1:0] vecSel,
  output logic             fetchNext
);

  srcCode_e sel;

  always_comb begin
    sel = SRC_NONE;
    if (instrEnd) begin
      if (!state.mask && state.extPend)      sel = SRC_EXT;
      else if (!state.mask && state.tmrPend) sel = SRC_TMR;
      else if (swiDecode)                    sel = SRC_SWI;
    end
  end

  assign takeInt   = (sel != SRC_NONE);
  assign fetchNext = instrEnd & ~takeInt;
  assign srcCode   = sel;

  for (genvar i = 0; i < VEC_W; i++) begin : g_vec
    assign vecSel[i] = (sel == srcCode_e'(2'(i + 1)));
  end

  assign strobe.enter  = takeInt;
  assign strobe.ackExt = (sel == SRC_EXT);
  assign strobe.ackTmr = (sel == SRC_TMR);

  // R5: decisions only at a boundary
  a_r5_boundary_only: assert property (@(posedge clk) disable iff (rst)
    !instrEnd |-> (!takeInt && !fetchNext));

  // R11: vector select never has two bits
  a_r11_vec_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(vecSel));

  // R8: software taken only when no eligible hardware request
  a_r8_swi_rank: assert property (@(posedge clk) disable iff (rst)
    (srcCode == SRC_SWI) |-> (state.mask || (!state.extPend && !state.tmrPend)));

endmodule

// File: rtl/intArbiter.sv
module intArbiter
  import intArbPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       extReqN,
  input  logic       tmrPulse,
  input  logic       instrEnd,
  input  logic       swiDecode,
  input  logic       rtiStrobe,
  input  logic       stackedMask,
  input  logic       maskLoad,
  input  logic       maskLoadVal,
  output logic       takeInt,
  output logic [1:0] srcCode,
  output logic [2:0] vecSel,
  output logic       setMask,
  output logic       ackExt,
  output logic       ackTmr,
  output logic       fetchNext,
  output logic       maskOut
);

  ctlStrobe_t strobe;
  pendState_t state;

  intArbPending #(.SYNC_STAGES(SYNC_STAGES)) i_pend (
    .clk         (clk),
    .rst         (rst),
    .extReqN     (extReqN),
    .tmrPulse    (tmrPulse),
    .rtiStrobe   (rtiStrobe),
    .stackedMask (stackedMask),
    .maskLoad    (maskLoad),
    .maskLoadVal (maskLoadVal),
    .strobe      (strobe),
    .state       (state)
  );

  intArbControl i_ctl (
    .clk       (clk),
    .rst       (rst),
    .instrEnd  (instrEnd),
    .swiDecode (swiDecode),
    .state     (state),
    .strobe    (strobe),
    .takeInt   (takeInt),
    .srcCode   (srcCode),
    .vecSel    (vecSel),
    .fetchNext (fetchNext)
  );

  assign setMask = strobe.enter;
  assign ackExt  = strobe.ackExt;
  assign ackTmr  = strobe.ackTmr;
  assign maskOut = state.mask;

  // R1: reset leaves the mask set
  a_r1_reset_mask: assert property (@(posedge clk)
    rst |=> maskOut);

endmodule

// File: tb/test_intArbiter.sv
module test_intArbiter;

  localparam int NSYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic extReqN = 1'b1, tmrPulse = 1'b0, instrEnd = 1'b0, swiDecode = 1'b0;
  logic rtiStrobe = 1'b0, stackedMask = 1'b0, maskLoad = 1'b0, maskLoadVal = 1'b0;
  logic takeInt, setMask, ackExt, ackTmr, fetchNext, maskOut;
  logic [1:0] srcCode;
  logic [2:0] vecSel;

  int compared = 0;
  int mismatched = 0;
  string phaseTag = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  intArbiter #(.SYNC_STAGES(NSYNC)) i_intArbiter (
    .clk(clk), .rst(rst), .extReqN(extReqN), .tmrPulse(tmrPulse),
    .instrEnd(instrEnd), .swiDecode(swiDecode), .rtiStrobe(rtiStrobe),
    .stackedMask(stackedMask), .maskLoad(maskLoad), .maskLoadVal(maskLoadVal),
    .takeInt(takeInt), .srcCode(srcCode), .vecSel(vecSel), .setMask(setMask),
    .ackExt(ackExt), .ackTmr(ackTmr), .fetchNext(fetchNext), .maskOut(maskOut)
  );

  // ---------------- behavioural reference model ----------------
  bit mValid = 0;
  bit mMask, mExt, mTmr, mLast;
  bit pinQ[$];

  function automatic int decide();
    if (!instrEnd) return 0;
    if (!mMask && mExt) return 3;
    if (!mMask && mTmr) return 2;
    if (swiDecode) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mMask = 1; mExt = 0; mTmr = 0; mLast = 1;
      pinQ = {};
      for (int i = 0; i < NSYNC; i++) pinQ.push_back(1'b1);
      mValid = 1;
    end else if (mValid) begin
      int d;
      bit fell;
      d = decide();
      fell = mLast && !pinQ[NSYNC-1];
      mExt = fell || (mExt && d != 3);
      mTmr = tmrPulse || (mTmr && d != 2);
      if (d != 0) mMask = 1;
      else if (rtiStrobe) mMask = stackedMask;
      else if (maskLoad) mMask = maskLoadVal;
      mLast = pinQ[NSYNC-1];
      void'(pinQ.pop_back());
      pinQ.push_front(extReqN);
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (mValid && !done) begin
      int d;
      logic [10:0] exp, act;
      d = decide();
      exp = {d != 0, 2'(d), (d == 3), (d == 2), (d == 1), d != 0, d == 3, d == 2,
             instrEnd && d == 0, mMask};
      act = {takeInt, srcCode, vecSel, setMask, ackExt, ackTmr, fetchNext, maskOut};
      compared++;
      if (act !== exp) begin
        mismatched++;
        $display("FAIL %s t=%0t outputs act=%b exp=%b", phaseTag, $time, act, exp);
      end
    end
  end

  // explicit point checks, sampled at negedge
  task automatic expectBit(string tag, logic actual, logic expected);
    compared++;
    if (actual !== expected) begin
      mismatched++;
      $display("FAIL %s t=%0t act=%b exp=%b", tag, $time, actual, expected);
    end
  endtask

  task automatic drive(logic pin, logic tp, logic ie, logic swi,
                       logic rti, logic sm, logic ml, logic mv);
    @(posedge clk); #1;
    extReqN = pin; tmrPulse = tp; instrEnd = ie; swiDecode = swi;
    rtiStrobe = rti; stackedMask = sm; maskLoad = ml; maskLoadVal = mv;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(extReqN, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 / R10: reset state and plain fetch
    phaseTag = "R1";
    drive(1, 0, 1, 0, 0, 0, 0, 0);
    @(negedge clk);
    expectBit("R1", maskOut, 1'b1);
    expectBit("R10", fetchNext, 1'b1);
    expectBit("R1", takeInt, 1'b0);
    idle(1);
    // R4: masked requests latch
    phaseTag = "R4";
    drive(0, 1, 0, 0, 0, 0, 0, 0);
    idle(4);
    drive(extReqN, 0, 1, 0, 0, 0, 0, 0);
    @(negedge clk);
    expectBit("R4", takeInt, 1'b0);
    drive(extReqN, 0, 0, 0, 0, 0, 1, 0);
    // R6 / R11: both pending, external first
    phaseTag = "R6";
    drive(extReqN, 0, 1, 0, 0, 0, 0, 0);
    @(negedge clk);
    expectBit("R6", ackExt, 1'b1);
    expectBit("R11", srcCode == 2'b11 && vecSel == 3'b100, 1'b1);
    phaseTag = "R7";
    drive(extReqN, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    expectBit("R7", maskOut, 1'b1);
    // R9: return restores mask, timer then taken
    phaseTag = "R9";
    drive(extReqN, 0, 0, 0, 1, 0, 1, 1);
    drive(extReqN, 0, 1, 0, 0, 0, 0, 0);
    @(negedge clk);
    expectBit("R9", ackTmr, 1'b1);
    expectBit("R11", srcCode == 2'b10 && vecSel == 3'b010, 1'b1);
    // R2: held low pin does not re-pend
    phaseTag = "R2";
    drive(extReqN, 0, 0, 0, 0, 0, 1, 0);
    idle(5);
    drive(extReqN, 0, 1, 0, 0, 0, 0, 0);
    @(negedge clk);
    expectBit("R2", takeInt, 1'b0);
    drive(1, 0, 0, 0, 0, 0, 0, 0);
    idle(3);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    idle(4);
    drive(extReqN, 0, 1, 0, 0, 0, 0, 0);
    @(negedge clk);
    expectBit("R2", ackExt, 1'b1);
    // R3: pulse with its own acknowledge keeps pending
    phaseTag = "R3";
    drive(extReqN, 1, 0, 0, 0, 0, 1, 0);
    drive(extReqN, 1, 1, 0, 0, 0, 0, 0);
    @(negedge clk);
    expectBit("R3", ackTmr, 1'b1);
    drive(extReqN, 0, 0, 0, 0, 0, 1, 0);
    drive(extReqN, 0, 1, 0, 0, 0, 0, 0);
    @(negedge clk);
    expectBit("R3", ackTmr, 1'b1);
    // R8: software with mask set, and against hardware
    phaseTag = "R8";
    drive(extReqN, 0, 1, 1, 0, 0, 0, 0);
    @(negedge clk);
    expectBit("R8", srcCode == 2'b01 && vecSel == 3'b001, 1'b1);
    drive(extReqN, 1, 0, 0, 0, 0, 1, 0);
    drive(extReqN, 0, 1, 1, 0, 0, 0, 0);
    @(negedge clk);
    expectBit("R8", ackTmr, 1'b1);
    // R5: no decision without instrEnd
    phaseTag = "R5";
    drive(extReqN, 1, 0, 0, 0, 0, 1, 0);
    drive(extReqN, 0, 0, 1, 0, 0, 0, 0);
    @(negedge clk);
    expectBit("R5", takeInt, 1'b0);
    // random mix against the model
    phaseTag = "RND";
    for (int i = 0; i < 20000; i++) begin
      logic pin;
      pin = ($urandom_range(0, 7) == 0) ? ~extReqN : extReqN;
      drive(pin, $urandom_range(0, 9) == 0, $urandom_range(0, 2) == 0,
            $urandom_range(0, 7) == 0, $urandom_range(0, 15) == 0,
            1'($urandom_range(0, 1)), $urandom_range(0, 11) == 0,
            1'($urandom_range(0, 1)));
    end
    idle(2);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule